// File: doc/BRIEF.md
# Dual-Band Dual-Modulus Prescaler

This block is a cycle-accurate model of a phase-switching prescaler for an integer-N synthesizer. It runs on the input clock and produces one divided clock period, a division cycle, for every N or N+1 input periods. A modulus input chooses between N and N+1. A band input chooses the lower pair (7/8 by default) or the upper pair (15/16 by default). The upper pair keeps the odd member, so the upper band is not a doubling of the lower pair.

The divider is a chain of divide-by-2 cells. The first cell is the full-rate stage. The next two cells form the four-phase stage. Cells above those extend the chain for the upper band. A single 2-to-1 selector picks which stage drives the divided clock and the end-of-division strobe. The phase-advance step that adds or removes one input period is applied only when a new division cycle is loaded. The end-of-division strobe lasts one input cycle, so downstream program and swallow counters can use it as a count enable.

Top module: `dualband_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `div_clk` = 0 and `eod_pulse` = 0. The first division cycle after reset uses the lower band at the larger modulus and lasts 8 input cycles, counting the cycle in which reset is released.
- R2: In the lower band (`band_sel` = 0), a division cycle lasts 8 input cycles when `mod_sel` = 1 and 7 input cycles when `mod_sel` = 0.
- R3: In the upper band (`band_sel` = 1), a division cycle lasts 16 input cycles when `mod_sel` = 1 and 15 input cycles when `mod_sel` = 0.
- R4: `mod_sel` and `band_sel` are sampled only at the clock edge that ends the cycle in which `eod_pulse` is high, and they govern the next division cycle. Changes at any other time do not alter the current cycle's length or its `div_clk` waveform.
- R5: `eod_pulse` is high for exactly one input cycle per division cycle: the last one.
- R6: `div_clk` is low at the start of every division cycle. It is high for exactly the last 4 input cycles (lower band) or the last 8 input cycles (upper band) of the cycle.
- R7: A band change never produces a division cycle shorter than 7 or longer than 16 input cycles. The first cycle after the change belongs wholly to the new band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | 1 selects the larger modulus, 0 the smaller |
| band_sel | input | 1 | 0 selects the lower pair, 1 the upper pair |
| div_clk | output | 1 | Divided clock |
| eod_pulse | output | 1 | High during the last input cycle of each division cycle |

## Verification
Most faults inside the divider chain or the band register show at the ports within one division cycle. A stuck cell, a wrong load value or a mis-gated upper stage moves the end-of-division strobe by at least one input period, or suppresses it. A wrong selector leg changes the high time of the divided clock at once. A fault in the sampling point of the modulus or band input shows up only in the division cycle that follows a mid-cycle input change. That is why the directed scenarios toggle inputs both away from and at the strobe.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic {
      BAND_LO = 1'b0,
      BAND_HI = 1'b1
   } band_e;

   // number of input periods in one division cycle
   function automatic int cycle_len(input int stages, input logic extra);
      return (1 << stages) - (extra ? 0 : 1);
   endfunction
endpackage

// File: rtl/psc_div2_cell.sv
module psc_div2_cell (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic load_val,
   input  logic tog,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= 1'b0;
      else if (load) q <= load_val;
      else if (tog)  q <= ~q;
   end
endmodule

// File: rtl/psc_band_mux.sv
module psc_band_mux #(
   parameter int W = 2
) (
   input  logic         sel,
   input  logic [W-1:0] in_lo,
   input  logic [W-1:0] in_hi,
   output logic [W-1:0] y
);
   assign y = sel ? in_hi : in_lo;
endmodule

// File: rtl/dualband_prescaler.sv
module dualband_prescaler #(
   parameter int LO_STAGES = 3,  // lower pair: 2^LO-1 / 2^LO
   parameter int HI_STAGES = 1   // extra cells used only by the upper band
) (
   input  logic clk,
   input  logic rst,
   input  logic mod_sel,
   input  logic band_sel,
   output logic div_clk,
   output logic eod_pulse
);
   import psc_pkg::*;

   localparam int TOT = LO_STAGES + HI_STAGES;

   generate
      if (LO_STAGES < 3) begin : g_bad_lo
         $error("LO_STAGES must cover the full-rate cell and the four-phase stage");
      end
      if (HI_STAGES < 1) begin : g_bad_hi
         $error("HI_STAGES must be at least 1");
      end
      if (TOT > 16) begin : g_bad_tot
         $error("chain longer than 16 cells");
      end
   endgenerate

   band_e            band_q;
   logic [TOT-1:0]   q;
   logic [TOT:0]     carry;
   logic [1:0]       sel_out;
   logic             end_now;

   assign carry[0] = 1'b1;

   // Stage 0 is the full-rate divide-by-2; stages 1..2 form the four-phase
   // stage whose 2-bit value is the phase pointer; upper cells run only in
   // the upper band.
   generate
      for (genvar i = 0; i < TOT; i++) begin : g_cell
         logic tog_i;
         logic ld_val;
         if (i < LO_STAGES) begin : g_lo
            assign tog_i = carry[i];
         end else begin : g_hi
            assign tog_i = carry[i] & (band_q == BAND_HI);
         end
         if (i == 0) begin : g_front
            // phase advance: start at 1 skips one input period
            assign ld_val = ~mod_sel;
         end else begin : g_rest
            assign ld_val = 1'b0;
         end
         psc_div2_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .load     (end_now),
            .load_val (ld_val),
            .tog      (tog_i),
            .q        (q[i])
         );
         assign carry[i+1] = carry[i] & q[i];
      end
   endgenerate

   // single 2-to-1 selection of the stage that ends the cycle
   psc_band_mux #(.W(2)) u_sel (
      .sel   (band_q == BAND_HI),
      .in_lo ({carry[LO_STAGES], q[LO_STAGES-1]}),
      .in_hi ({carry[TOT],       q[TOT-1]}),
      .y     (sel_out)
   );

   assign end_now = sel_out[1];

   always_ff @(posedge clk) begin
      if (rst)          band_q <= BAND_LO;
      else if (end_now) band_q <= band_e'(band_sel);
   end

   assign div_clk   = sel_out[0];
   assign eod_pulse = end_now;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
   parameter int LO_STAGES = 3,
   parameter int HI_STAGES = 1
) (
   input logic clk,
   input logic rst,
   input logic mod_sel,
   input logic band_sel,
   input logic div_clk,
   input logic eod_pulse
);
   localparam int TOT  = LO_STAGES + HI_STAGES;
   localparam int RW   = TOT + 1;
   localparam int MAXL = 1 << TOT;
   localparam int LOF  = 1 << LO_STAGES;

   logic [RW-1:0] run;
   logic          band_c;
   logic          ext_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         run    <= RW'(1);
         band_c <= 1'b0;
         ext_c  <= 1'b1;
      end else if (eod_pulse) begin
         run    <= RW'(1);
         band_c <= band_sel;
         ext_c  <= mod_sel;
      end else begin
         run    <= run + RW'(1);
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!div_clk && !eod_pulse)); // R1

   AST_LOWER_LEN: assert property (@(posedge clk) disable iff (rst)
      (eod_pulse && !band_c) |-> (int'(run) == LOF - (ext_c ? 0 : 1))); // R2

   AST_UPPER_LEN: assert property (@(posedge clk) disable iff (rst)
      (eod_pulse && band_c) |-> (int'(run) == MAXL - (ext_c ? 0 : 1))); // R3

   AST_EOD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      eod_pulse |=> !eod_pulse); // R5

   AST_DIV_LOW_START: assert property (@(posedge clk) disable iff (rst)
      eod_pulse |=> !div_clk); // R6

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
      (int'(run) <= MAXL)); // R7
endmodule

bind dualband_prescaler psc_checker #(
   .LO_STAGES (LO_STAGES),
   .HI_STAGES (HI_STAGES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mod_sel   (mod_sel),
   .band_sel  (band_sel),
   .div_clk   (div_clk),
   .eod_pulse (eod_pulse)
);

// File: tb/dualband_prescaler_test.sv
module dualband_prescaler_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mod_sel = 1'b0;
   logic band_sel = 1'b0;
   logic div_clk;
   logic eod_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #4 clk = ~clk;   // 125 MHz

   dualband_prescaler uut (
      .clk       (clk),
      .rst       (rst),
      .mod_sel   (mod_sel),
      .band_sel  (band_sel),
      .div_clk   (div_clk),
      .eod_pulse (eod_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts input cycles until eod is seen; n starts at 'start'
   task automatic run_cycle(input int start, output int len, output int hi);
      int n = start;
      int h = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         n++;
         if (div_clk) h++;
         if (eod_pulse) break;
      end
      len = n;
      hi  = h;
   endtask

   task automatic t_reset;
      int len, hi;
      rst = 1'b1;
      mod_sel = 1'b0; band_sel = 1'b1;
      repeat (3) @(negedge clk);
      check(div_clk == 1'b0, "R1 div_clk in reset", div_clk, 0);
      check(eod_pulse == 1'b0, "R1 eod in reset", eod_pulse, 0);
      rst = 1'b0;
      // release cycle itself is the first input cycle of the division cycle
      run_cycle(1, len, hi);
      check(len == 8, "R1 first cycle length", len, 8);
   endtask

   task automatic t_lower;
      int len, hi;
      // at this point we are at the eod negedge
      band_sel = 1'b0; mod_sel = 1'b0;
      run_cycle(0, len, hi);
      check(len == 7, "R2 lower small modulus", len, 7);
      check(hi == 4, "R6 lower high time (7)", hi, 4);
      mod_sel = 1'b1;
      @(negedge clk);
      check(eod_pulse == 1'b0, "R5 eod one cycle", eod_pulse, 0);
      check(div_clk == 1'b0, "R6 div low at start", div_clk, 0);
      run_cycle(1, len, hi);
      check(len == 8, "R2 lower large modulus", len, 8);
      check(hi == 4, "R6 lower high time (8)", hi, 4);
   endtask

   task automatic t_upper;
      int len, hi;
      band_sel = 1'b1; mod_sel = 1'b1;
      run_cycle(0, len, hi);
      check(len == 16, "R3 upper large modulus", len, 16);
      check(hi == 8, "R6 upper high time (16)", hi, 8);
      mod_sel = 1'b0;
      run_cycle(0, len, hi);
      check(len == 15, "R3 upper small modulus", len, 15);
      check(hi == 8, "R6 upper high time (15)", hi, 8);
   endtask

   task automatic t_midcycle;
      int len, hi;
      // upper band, large modulus for the next cycle
      band_sel = 1'b1; mod_sel = 1'b1;
      repeat (3) @(negedge clk);
      band_sel = 1'b0; mod_sel = 1'b0;   // pulse away from eod
      repeat (3) @(negedge clk);
      band_sel = 1'b1; mod_sel = 1'b1;   // restored before eod
      run_cycle(6, len, hi);
      check(len == 16, "R4 mid-cycle pulse ignored", len, 16);
      check(hi == 8, "R4 waveform unchanged", hi, 8);
      // change and hold: current cycle keeps its length, next follows
      repeat (2) @(negedge clk);
      mod_sel = 1'b0;
      run_cycle(2, len, hi);
      check(len == 16, "R4 held change not applied mid-cycle", len, 16);
      run_cycle(0, len, hi);
      check(len == 15, "R4 held change applied next cycle", len, 15);
   endtask

   task automatic t_band_switch;
      int len, hi;
      band_sel = 1'b0; mod_sel = 1'b0;
      run_cycle(0, len, hi);
      check(len == 7, "R7 upper to lower first cycle", len, 7);
      band_sel = 1'b1; mod_sel = 1'b0;
      run_cycle(0, len, hi);
      check(len == 15, "R7 lower to upper first cycle", len, 15);
      check(hi == 8, "R7 high time after switch", hi, 8);
      band_sel = 1'b0; mod_sel = 1'b1;
      run_cycle(0, len, hi);
      check(len == 8, "R7 back to lower", len, 8);
   endtask

   initial begin
      t_reset;
      t_lower;
      t_upper;
      t_midcycle;
      t_band_switch;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule